// File: doc/BRIEF.md
# Sticky Error Status and Fault Address Logger

This block keeps a record of hardware error events for later inspection by software. Error detectors present at most one event per clock cycle. Each event carries a type index, a physical address, a 9-bit data syndrome, a 4-bit tag syndrome, the privilege mode in force, and a tag that marks it as one of the ECC errors of a multi-beat bus transfer. The block holds a 64-bit status word and a separate fault address register. The status word contains one sticky bit per error type, a repeat flag, a privilege capture bit, and two read-only syndrome fields.

Error types fall into three classes: uncorrectable, software-correctable and hardware-corrected. The class sets how repeats are flagged. It also sets which logged event owns the single address register and each syndrome field. Each of the three capture registers records its owner. It stays frozen until software clears that owner's sticky bit, and then it takes the next qualifying event. Software reads both registers through a small CSR port. It clears status bits by writing ones to them. A read never changes any state.

Top module: `err_status_log`

## Requirements
- R1: Reset sets the status word, the fault address register and all capture ownership to zero.
- R2: An accepted event of type t (0..18) sets status bit 33+t. That bit stays set until software writes a 1 to it. Bits of other types accumulate independently.
- R3: A CSR write with `csr_sel`=0 clears exactly the status bits 53, 52 and 51:33 that are 1 in the write data. Writes to the syndrome fields (bits 19:16 and 8:0) and to the address register (`csr_sel`=1) have no effect. Reads never change state.
- R4: When an event sets a status bit in the same cycle that software clears that bit, the bit ends up set.
- R5: Bit 53 is set when an event of an uncorrectable or software-correctable type arrives while its own status bit is already set. It is not set by a repeat of a hardware-corrected type.
- R6: Bit 52 takes the value of `ev_priv` on every accepted event.
- R7: When an event has `ev_burst`=1 and the same `ev_txn` as the last accepted burst event, it is discarded entirely. It changes no status bit, no flag and no capture.
- R8: Capture priority puts class first (uncorrectable types 1,2,4,6,8,10,11,12,14,16,17,18 above software-correctable type 9, which is above all other types, which are hardware-corrected). Within a class the lower type index ranks higher. The address register (read at `csr_sel`=1, zero-extended) takes an event's address only if it has no valid owner or the new event strictly outranks its owner.
- R9: A capture register unlocks when its owner's status bit is cleared, even if other bits stay set. It keeps its value until the next capture.
- R10: The data syndrome field (bits 8:0) captures only for types 0..9, 12 and 13. The tag syndrome field (bits 19:16) captures only for types 14 and 15. Each field follows the ownership rules of R8 and R9 independently.
- R11: An event whose type index is 19 or above is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | An error event is present this cycle |
| ev_type | input | 5 | Error type index |
| ev_addr | input | ADDR_W | Physical address of the failing access |
| ev_dsyn | input | 9 | Data ECC syndrome |
| ev_tsyn | input | 4 | Tag ECC syndrome |
| ev_priv | input | 1 | Privileged mode when the error was detected |
| ev_burst | input | 1 | Event is an ECC error within a multi-beat transfer |
| ev_txn | input | TXN_W | Transfer identifier for burst events |
| csr_en | input | 1 | CSR access strobe |
| csr_we | input | 1 | CSR access is a write |
| csr_sel | input | 1 | 0 selects the status word, 1 selects the address register |
| csr_wdata | input | 64 | Write data; ones clear status bits |
| csr_rdata | output | 64 | Read data of the selected register |

## Verification
Properties are checked on every cycle. Status bits never fall without a clear write. Reads leave the state untouched. A valid capture owner always has its sticky bit set. The address and repeat flag move only after an event. An out-of-range type changes nothing. Other behaviour needs the bench's scenarios to show it: the exact priority outcome among mixed classes, the held value after an unlock, the clear-versus-detect race resolving to a fresh capture, and the burst filter discarding later beats of the same transfer.

// File: rtl/err_status_log.sv
module err_status_log #(
  parameter int          ADDR_W    = 40,
  parameter int          TXN_W     = 4,
  parameter logic [18:0] UNC_MASK  = 19'h75D56,
  parameter logic [18:0] SWC_MASK  = 19'h00200,
  parameter logic [18:0] DSYN_MASK = 19'h033FF,
  parameter logic [18:0] TSYN_MASK = 19'h0C000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [4:0]        ev_type,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic [8:0]        ev_dsyn,
  input  logic [3:0]        ev_tsyn,
  input  logic              ev_priv,
  input  logic              ev_burst,
  input  logic [TXN_W-1:0]  ev_txn,
  input  logic              csr_en,
  input  logic              csr_we,
  input  logic              csr_sel,
  input  logic [63:0]       csr_wdata,
  output logic [63:0]       csr_rdata
);
  localparam int NT = 19;
  localparam int LO = 33;
  localparam int PAD = 32 - NT;
  localparam logic [31:0] UNC32 = 32'(UNC_MASK);
  localparam logic [31:0] SWC32 = 32'(SWC_MASK);
  localparam logic [31:0] DSY32 = 32'(DSYN_MASK);
  localparam logic [31:0] TSY32 = 32'(TSYN_MASK);

  function automatic logic [6:0] rank(input logic [4:0] t);
    logic [1:0] c;
    c = UNC32[t] ? 2'd2 : (SWC32[t] ? 2'd1 : 2'd0);
    return {c, 5'd31 - t};
  endfunction

  logic [NT-1:0]     sticky, kept, hit;
  logic [31:0]       sticky32, kept32;
  logic              multi, priv;
  logic              bseen;
  logic [TXN_W-1:0]  btxn;
  logic              a_v, d_v, t_v;
  logic [4:0]        a_own, d_own, t_own;
  logic [ADDR_W-1:0] addr_q;
  logic [8:0]        dsyn_q;
  logic [3:0]        tsyn_q;

  logic        clr_st, burst_drop, take, rep;
  logic [63:0] wclr;
  logic        a_eff, d_eff, t_eff, a_cap, d_cap, t_cap;
  logic        unused_wdata;

  assign clr_st     = csr_en && csr_we && !csr_sel;
  assign wclr       = clr_st ? csr_wdata : 64'd0;
  assign kept       = sticky & ~wclr[LO +: NT];
  assign sticky32   = {{PAD{1'b0}}, sticky};
  assign kept32     = {{PAD{1'b0}}, kept};
  assign burst_drop = ev_burst && bseen && (ev_txn == btxn);
  assign take       = ev_valid && (ev_type < 5'(NT)) && !burst_drop;
  assign hit        = take ? ({{(NT-1){1'b0}}, 1'b1} << ev_type) : '0;
  assign rep        = take && sticky32[ev_type] && (UNC32[ev_type] || SWC32[ev_type]);

  assign a_eff = a_v && kept32[a_own];
  assign d_eff = d_v && kept32[d_own];
  assign t_eff = t_v && kept32[t_own];
  assign a_cap = take && (!a_eff || rank(ev_type) > rank(a_own));
  assign d_cap = take && DSY32[ev_type] && (!d_eff || rank(ev_type) > rank(d_own));
  assign t_cap = take && TSY32[ev_type] && (!t_eff || rank(ev_type) > rank(t_own));

  assign unused_wdata = ^{csr_wdata[63:54], csr_wdata[32:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky <= '0;
      multi  <= 1'b0;
      priv   <= 1'b0;
      bseen  <= 1'b0;
      btxn   <= '0;
      a_v    <= 1'b0;
      d_v    <= 1'b0;
      t_v    <= 1'b0;
      a_own  <= '0;
      d_own  <= '0;
      t_own  <= '0;
      addr_q <= '0;
      dsyn_q <= '0;
      tsyn_q <= '0;
    end else begin
      sticky <= kept | hit;
      multi  <= (multi && !wclr[53]) || rep;
      priv   <= take ? ev_priv : (priv && !wclr[52]);
      if (take && ev_burst) begin
        bseen <= 1'b1;
        btxn  <= ev_txn;
      end
      a_v <= a_cap || a_eff;
      d_v <= d_cap || d_eff;
      t_v <= t_cap || t_eff;
      if (a_cap) begin
        a_own  <= ev_type;
        addr_q <= ev_addr;
      end
      if (d_cap) begin
        d_own  <= ev_type;
        dsyn_q <= ev_dsyn;
      end
      if (t_cap) begin
        t_own  <= ev_type;
        tsyn_q <= ev_tsyn;
      end
    end
  end

  assign csr_rdata = csr_sel ? 64'(addr_q)
                             : {10'd0, multi, priv, sticky, 13'd0, tsyn_q, 7'd0, dsyn_q};

  a_r2_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_st |=> (($past(sticky) & ~sticky) == '0));

  a_r3_read_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && !csr_we && !ev_valid) |=> ($stable(sticky) && $stable(multi) && $stable(priv)));

  a_r4_detect_wins: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> sticky32[$past(ev_type)]);

  a_r5_multi_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(multi) |-> $past(ev_valid));

  a_r8_addr_owner_live: assert property (@(posedge clk) disable iff (!rst_n)
    a_v |-> sticky32[a_own]);

  a_r9_addr_moves_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_q) |-> $past(ev_valid));

  a_r10_dsyn_owner_live: assert property (@(posedge clk) disable iff (!rst_n)
    d_v |-> (sticky32[d_own] && DSY32[d_own]));

  a_r10_tsyn_owner_live: assert property (@(posedge clk) disable iff (!rst_n)
    t_v |-> (sticky32[t_own] && TSY32[t_own]));

  a_r11_range_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_type >= 5'(NT) && !clr_st) |=> ($stable(sticky) && $stable(addr_q)));
endmodule

// File: tb/err_status_log_test.sv
`timescale 1ns/1ps
module err_status_log_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic [4:0]  ev_type = '0;
  logic [39:0] ev_addr = '0;
  logic [8:0]  ev_dsyn = '0;
  logic [3:0]  ev_tsyn = '0;
  logic        ev_priv = 1'b0;
  logic        ev_burst = 1'b0;
  logic [3:0]  ev_txn = '0;
  logic        csr_en = 1'b0;
  logic        csr_we = 1'b0;
  logic        csr_sel = 1'b0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  err_status_log uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_type(ev_type), .ev_addr(ev_addr),
    .ev_dsyn(ev_dsyn), .ev_tsyn(ev_tsyn), .ev_priv(ev_priv), .ev_burst(ev_burst),
    .ev_txn(ev_txn), .csr_en(csr_en), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
  );

  typedef struct packed {
    logic        wr;
    logic [4:0]  typ;
    logic [15:0] addr;
    logic [8:0]  dsyn;
    logic [3:0]  tsyn;
    logic        priv;
    logic [18:0] clr;
    logic        xm;
    logic        xp;
    logic [18:0] xs;
    logic [3:0]  xt;
    logic [8:0]  xd;
    logic [15:0] xa;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b0, 5'd0,  16'h100, 9'h011, 4'h0, 1'b1, 19'h0, 1'b0, 1'b1, 19'h00001, 4'h0, 9'h011, 16'h100}, // R2 R6 R8 first capture
    '{1'b0, 5'd0,  16'h200, 9'h022, 4'h0, 1'b0, 19'h0, 1'b0, 1'b0, 19'h00001, 4'h0, 9'h011, 16'h100}, // R5 hw repeat, R8 no overwrite
    '{1'b0, 5'd1,  16'h300, 9'h033, 4'h0, 1'b1, 19'h0, 1'b0, 1'b1, 19'h00003, 4'h0, 9'h033, 16'h300}, // R8 unc beats hw
    '{1'b0, 5'd9,  16'h400, 9'h044, 4'h0, 1'b0, 19'h0, 1'b0, 1'b0, 19'h00203, 4'h0, 9'h033, 16'h300}, // R8 swc below unc
    '{1'b0, 5'd1,  16'h500, 9'h055, 4'h0, 1'b0, 19'h0, 1'b1, 1'b0, 19'h00203, 4'h0, 9'h033, 16'h300}, // R5 unc repeat
    '{1'b0, 5'd14, 16'h600, 9'h066, 4'h9, 1'b1, 19'h0, 1'b1, 1'b1, 19'h04203, 4'h9, 9'h033, 16'h300}, // R8 lower index wins, R10
    '{1'b1, 5'd0,  16'h000, 9'h000, 4'h0, 1'b0, 19'h2, 1'b1, 1'b1, 19'h04201, 4'h9, 9'h033, 16'h300}, // R9 unlock holds value
    '{1'b0, 5'd9,  16'h700, 9'h077, 4'h0, 1'b0, 19'h0, 1'b1, 1'b0, 19'h04201, 4'h9, 9'h077, 16'h700}, // R9 recapture
    '{1'b0, 5'd2,  16'h800, 9'h088, 4'h0, 1'b0, 19'h0, 1'b1, 1'b0, 19'h04205, 4'h9, 9'h088, 16'h800}  // R8 unc overwrites swc
  };

  function automatic logic [63:0] mk(logic m, logic p, logic [18:0] s, logic [3:0] t, logic [8:0] d);
    return {10'd0, m, p, s, 13'd0, t, 7'd0, d};
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    ev_valid = 1'b0; ev_burst = 1'b0; csr_en = 1'b0; csr_we = 1'b0; csr_sel = 1'b0; csr_wdata = '0;
  endtask

  task automatic set_ev(logic [4:0] t, logic [39:0] a, logic [8:0] d, logic [3:0] ts, logic p,
                        logic b, logic [3:0] x);
    ev_valid = 1'b1; ev_type = t; ev_addr = a; ev_dsyn = d; ev_tsyn = ts; ev_priv = p;
    ev_burst = b; ev_txn = x;
  endtask

  task automatic set_wr(logic sel, logic [63:0] d);
    csr_en = 1'b1; csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
  endtask

  task automatic expect_regs(string req, logic [63:0] st, logic [39:0] a);
    csr_sel = 1'b0; #1;
    check(req, csr_rdata, st);
    csr_sel = 1'b1; #1;
    check(req, csr_rdata, 64'(a));
    csr_sel = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    expect_regs("R1 reset", 64'd0, 40'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 9; i++) begin
      if (VECS[i].wr) set_wr(1'b0, 64'(VECS[i].clr) << 33);
      else set_ev(VECS[i].typ, 40'(VECS[i].addr), VECS[i].dsyn, VECS[i].tsyn, VECS[i].priv, 1'b0, 4'd0);
      tick();
      expect_regs($sformatf("R2/R5/R6/R8/R9/R10 vector %0d", i),
                  mk(VECS[i].xm, VECS[i].xp, VECS[i].xs, VECS[i].xt, VECS[i].xd), 40'(VECS[i].xa));
    end

    // R3: reads leave state alone
    csr_en = 1'b1; csr_we = 1'b0; tick();
    csr_en = 1'b1; csr_we = 1'b0; tick();
    expect_regs("R3 read no clear", mk(1, 0, 19'h04205, 4'h9, 9'h088), 40'h800);

    // R3 R5: clear flag bits, syndrome write ignored
    set_wr(1'b0, (64'd1 << 53) | (64'd1 << 52) | 64'h000F_01FF); tick();
    expect_regs("R3 R5 flag clear, syndrome ignored", mk(0, 0, 19'h04205, 4'h9, 9'h088), 40'h800);

    // R3: address register write ignored
    set_wr(1'b1, '1); tick();
    expect_regs("R3 address write ignored", mk(0, 0, 19'h04205, 4'h9, 9'h088), 40'h800);

    // R4: detect and clear of same bit in one cycle
    set_ev(5'd2, 40'h900, 9'h099, 4'h0, 1'b1, 1'b0, 4'd0);
    set_wr(1'b0, 64'd1 << 35); tick();
    expect_regs("R4 detect wins", mk(1, 1, 19'h04205, 4'h9, 9'h099), 40'h900);

    // R11: out-of-range type
    set_ev(5'd25, 40'hF00, 9'h1FF, 4'hF, 1'b0, 1'b0, 4'd0); tick();
    expect_regs("R11 type ignored", mk(1, 1, 19'h04205, 4'h9, 9'h099), 40'h900);

    set_wr(1'b0, '1); tick();
    expect_regs("R3 clear all", mk(0, 0, 19'h0, 4'h9, 9'h099), 40'h900);

    // R7: burst filter
    set_ev(5'd1, 40'hA00, 9'h0AA, 4'h0, 1'b0, 1'b1, 4'd3); tick();
    expect_regs("R7 first burst beat", mk(0, 0, 19'h2, 4'h9, 9'h0AA), 40'hA00);
    set_ev(5'd2, 40'hB00, 9'h0BB, 4'h0, 1'b1, 1'b1, 4'd3); tick();
    expect_regs("R7 later beat dropped", mk(0, 0, 19'h2, 4'h9, 9'h0AA), 40'hA00);
    set_ev(5'd1, 40'hB10, 9'h0BC, 4'h0, 1'b0, 1'b1, 4'd3); tick();
    expect_regs("R7 no repeat flag", mk(0, 0, 19'h2, 4'h9, 9'h0AA), 40'hA00);
    set_ev(5'd1, 40'hC00, 9'h0CC, 4'h0, 1'b0, 1'b1, 4'd4); tick();
    expect_regs("R7 new transfer logged", mk(1, 0, 19'h2, 4'h9, 9'h0AA), 40'hA00);

    // R1: reset mid-run
    rst_n = 1'b0; tick(); tick();
    expect_regs("R1 mid-run reset", 64'd0, 40'd0);
    rst_n = 1'b1; @(negedge clk);

    // R10: tag syndrome ownership
    set_ev(5'd15, 40'hD00, 9'h1AA, 4'h5, 1'b0, 1'b0, 4'd0); tick();
    expect_regs("R10 tag capture hw", mk(0, 0, 19'h08000, 4'h5, 9'h000), 40'hD00);
    set_ev(5'd14, 40'hE00, 9'h1BB, 4'hC, 1'b0, 1'b0, 4'd0); tick();
    expect_regs("R10 tag overwrite unc", mk(0, 0, 19'h0C000, 4'hC, 9'h000), 40'hE00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule